// File: doc/BRIEF.md
# Rotating Unit-Element Selector for Multi-bit Feedback DACs

This block sits between the multi-bit quantizer of a delta-sigma loop and its unit-element feedback DACs. Every sampling clock it takes the quantizer's 4-bit code and turns it into a select vector over 15 unit elements. In averaging mode a circular pointer remembers where the previous run of elements stopped. Each new code turns on the next run of elements from that point, so every element is used equally often and element mismatch becomes noise shaped away from the signal band.

A runtime input can disable averaging. The block then drives a plain thermometer pattern that always starts at element 0. The quantizer samples on the rising clock edge. The select vector is launched on the falling edge that follows, which gives the loop its half-period excess delay. Two identical registered copies of the vector come out: one for the main resistor DAC and one for the loop-delay compensation capacitor DAC. A synchronous clear, also used for the periodic incremental-mode reset, empties the vector and returns the pointer to element 0.

Top module: `dwa_selector`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, both select outputs read all zeros and the rotation pointer is at element 0.
- R2: For an accepted code N (0 to 15), exactly N bits of the select vector are 1.
- R3: With `avg_en` = 1, the accepted code N turns on elements p, p+1, … p+N-1 (mod 15), where p is the current pointer; the pointer then becomes (p + N) mod 15.
- R4: A run that passes element 14 continues at element 0 (bit 0 of the vector).
- R5: With `avg_en` = 0, the accepted code N turns on bits 0 through N-1, and the pointer keeps its value for later averaging codes.
- R6: A `sync_clr` sampled high clears the select vector and puts the pointer at element 0; any code sampled in that same cycle is dropped.
- R7: Inputs are sampled on the rising edge, and the select vector changes only on the following falling edge; it is stable from a falling edge until the next falling edge.
- R8: When `code_valid` is sampled low (and no clear), the select vector and the pointer keep their values.
- R9: `sel_main` and `sel_eld` are always equal.
- R10: After a clear, with averaging on throughout, the numbers of times each element has been selected differ by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; rising edge samples, falling edge launches |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of pointer and select vector |
| code_valid | input | 1 | Marks `code` as a new quantizer result |
| code | input | CODE_W (4) | Quantizer output code, number of elements to turn on |
| avg_en | input | 1 | 1: rotating averaging, 0: fixed thermometer from element 0 |
| sel_main | output | 15 | Unit-element selects for the main resistor DAC; bit i is element i |
| sel_eld | output | 15 | Unit-element selects for the delay-compensation capacitor DAC |

## Verification
A corrupted pointer shows up at the very next falling edge with an accepted averaging code. The run begins at the wrong element, even though its popcount is still correct. For that reason the bench compares whole vectors against its own pointer model and does not rely on bit counts alone. A wrong modulo wrap appears only on codes that cross element 14. A pointer that drifts with averaging off appears only at the first averaging code after the thermometer interlude, so both cases are driven on purpose. Uneven element use builds up slowly, so it is measured over a long random run.

// File: rtl/dwa_pkg.sv
`timescale 1ns/1ps
package dwa_pkg;

  // Selection policy carried with each captured sample.
  typedef enum logic {
    SEL_THERMO = 1'b0,
    SEL_ROTATE = 1'b1
  } sel_mode_e;

  localparam int unsigned DWA_DEF_CODE_W = 4;

endpackage

// File: rtl/dwa_sample_reg.sv
`timescale 1ns/1ps
// Rising-edge capture of the quantizer result and control inputs.
module dwa_sample_reg
  import dwa_pkg::*;
#(
  parameter int unsigned CODE_W = DWA_DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code,
  input  logic              avg_en,
  output logic              cap_clr,
  output logic              cap_valid,
  output logic [CODE_W-1:0] cap_code,
  output sel_mode_e         cap_mode
);

  logic              clr_d;
  logic              valid_d;
  logic [CODE_W-1:0] code_d;
  sel_mode_e         mode_d;
  logic              code_ld;

  // Code and mode only reload when a new result arrives.
  always_comb begin
    clr_d   = sync_clr;
    valid_d = code_valid & ~sync_clr;
    code_ld = code_valid;
    code_d  = code;
    mode_d  = avg_en ? SEL_ROTATE : SEL_THERMO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_clr   <= 1'b0;
      cap_valid <= 1'b0;
    end else begin
      cap_clr   <= clr_d;
      cap_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_code <= '0;
      cap_mode <= SEL_THERMO;
    end else if (code_ld) begin
      cap_code <= code_d;
      cap_mode <= mode_d;
    end
  end

endmodule

// File: rtl/dwa_thermo_dec.sv
`timescale 1ns/1ps
// Binary code to thermometer pattern anchored at element 0.
module dwa_thermo_dec #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned NUM_ELEM = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0]   code,
  output logic [NUM_ELEM-1:0] thermo
);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_bit
    always_comb begin
      thermo[g] = (code > CODE_W'(g));
    end
  end

endmodule

// File: rtl/dwa_rotate.sv
`timescale 1ns/1ps
// Circular shift of the thermometer pattern by the pointer, modulo NUM_ELEM.
module dwa_rotate
  import dwa_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 15,
  localparam int unsigned PTR_W   = $clog2(NUM_ELEM)
) (
  input  logic [NUM_ELEM-1:0] thermo,
  input  logic [PTR_W-1:0]    ptr,
  input  sel_mode_e           mode,
  output logic [NUM_ELEM-1:0] sel
);

  logic [NUM_ELEM-1:0] rotated;

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    logic [PTR_W-1:0] src_idx;

    // Element g belongs to the run when (g - ptr) mod NUM_ELEM < code.
    always_comb begin
      if (PTR_W'(g) >= ptr) begin
        src_idx = PTR_W'(g) - ptr;
      end else begin
        src_idx = PTR_W'(g) + PTR_W'(NUM_ELEM) - ptr;
      end
      rotated[g] = thermo[src_idx];
    end
  end

  always_comb begin
    sel = (mode == SEL_ROTATE) ? rotated : thermo;
  end

endmodule

// File: rtl/dwa_ptr_acc.sv
`timescale 1ns/1ps
// Modulo-NUM_ELEM rotation pointer, updated on the launch (falling) edge.
module dwa_ptr_acc
  import dwa_pkg::*;
#(
  parameter int unsigned CODE_W   = DWA_DEF_CODE_W,
  parameter int unsigned NUM_ELEM = (1 << CODE_W) - 1,
  localparam int unsigned PTR_W   = $clog2(NUM_ELEM),
  localparam int unsigned SUM_W   = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_clr,
  input  logic              cap_valid,
  input  logic [CODE_W-1:0] cap_code,
  input  sel_mode_e         cap_mode,
  output logic [PTR_W-1:0]  ptr
);

  logic [SUM_W-1:0] sum_raw;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  // ptr < NUM_ELEM and code <= NUM_ELEM, so one conditional subtract wraps.
  always_comb begin
    sum_raw = SUM_W'(ptr) + SUM_W'(cap_code);
    if (sum_raw >= SUM_W'(NUM_ELEM)) begin
      sum_raw = sum_raw - SUM_W'(NUM_ELEM);
    end
    ptr_en = cap_clr | (cap_valid & (cap_mode == SEL_ROTATE));
    ptr_d  = cap_clr ? '0 : sum_raw[PTR_W-1:0];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/dwa_selector.sv
`timescale 1ns/1ps
// Rotating unit-element selector with half-cycle launch to two DACs.
module dwa_selector
  import dwa_pkg::*;
#(
  parameter int unsigned  CODE_W   = DWA_DEF_CODE_W,
  localparam int unsigned NUM_ELEM = (1 << CODE_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic                code_valid,
  input  logic [CODE_W-1:0]   code,
  input  logic                avg_en,
  output logic [NUM_ELEM-1:0] sel_main,
  output logic [NUM_ELEM-1:0] sel_eld
);

  localparam int unsigned PTR_W = $clog2(NUM_ELEM);
  localparam int unsigned N_DAC = 2;

  logic                cap_clr;
  logic                cap_valid;
  logic [CODE_W-1:0]   cap_code;
  sel_mode_e           cap_mode;
  logic [PTR_W-1:0]    ptr;
  logic [NUM_ELEM-1:0] thermo;
  logic [NUM_ELEM-1:0] sel_new;
  logic [NUM_ELEM-1:0] sel_d;
  logic                sel_en;
  logic [NUM_ELEM-1:0] sel_q [N_DAC];

  dwa_sample_reg #(.CODE_W(CODE_W)) u_sample (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_clr   (sync_clr),
    .code_valid (code_valid),
    .code       (code),
    .avg_en     (avg_en),
    .cap_clr    (cap_clr),
    .cap_valid  (cap_valid),
    .cap_code   (cap_code),
    .cap_mode   (cap_mode)
  );

  dwa_thermo_dec #(.CODE_W(CODE_W), .NUM_ELEM(NUM_ELEM)) u_thermo (
    .code   (cap_code),
    .thermo (thermo)
  );

  dwa_rotate #(.NUM_ELEM(NUM_ELEM)) u_rotate (
    .thermo (thermo),
    .ptr    (ptr),
    .mode   (cap_mode),
    .sel    (sel_new)
  );

  dwa_ptr_acc #(.CODE_W(CODE_W), .NUM_ELEM(NUM_ELEM)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_clr   (cap_clr),
    .cap_valid (cap_valid),
    .cap_code  (cap_code),
    .cap_mode  (cap_mode),
    .ptr       (ptr)
  );

  always_comb begin
    sel_en = cap_clr | cap_valid;
    sel_d  = cap_clr ? '0 : sel_new;
  end

  // One launch register per DAC so each drives only its own element switches.
  for (genvar d = 0; d < N_DAC; d++) begin : g_dac
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[d] <= '0;
      end else if (sel_en) begin
        sel_q[d] <= sel_d;
      end
    end
  end

  assign sel_main = sel_q[0];
  assign sel_eld  = sel_q[1];

endmodule

// File: rtl/dwa_selector_chk.sv
`timescale 1ns/1ps
// Port-level properties, bound into the selector.
module dwa_selector_chk #(
  parameter int unsigned  CODE_W   = 4,
  localparam int unsigned NUM_ELEM = (1 << CODE_W) - 1,
  localparam int unsigned VW       = NUM_ELEM + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_clr,
  input logic                code_valid,
  input logic [CODE_W-1:0]   code,
  input logic                avg_en,
  input logic [NUM_ELEM-1:0] sel_main,
  input logic [NUM_ELEM-1:0] sel_eld
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  assert_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(code_valid) && !$past(sync_clr)
      |-> $countones(sel_main) == int'($past(code)));

  assert_fixed_thermo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(code_valid) && !$past(sync_clr) && !$past(avg_en)
      |-> {1'b0, sel_main} == ((VW'(1) << $past(code)) - VW'(1)));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(sync_clr) |-> sel_main == '0);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(code_valid) && !$past(sync_clr) |-> $stable(sel_main));

  assert_copies_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_main == sel_eld);

endmodule

bind dwa_selector dwa_selector_chk #(.CODE_W(CODE_W)) u_dwa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_clr   (sync_clr),
  .code_valid (code_valid),
  .code       (code),
  .avg_en     (avg_en),
  .sel_main   (sel_main),
  .sel_eld    (sel_eld)
);

// File: tb/test_dwa_selector.sv
`timescale 1ns/1ps
module test_dwa_selector;

  localparam int      CODE_W     = 4;
  localparam int      NUM_ELEM   = (1 << CODE_W) - 1;
  localparam realtime CLK_PERIOD = 31.25;

  logic                clk;
  logic                rst_n;
  logic                sync_clr;
  logic                code_valid;
  logic [CODE_W-1:0]   code;
  logic                avg_en;
  logic [NUM_ELEM-1:0] sel_main;
  logic [NUM_ELEM-1:0] sel_eld;

  typedef struct {
    logic [NUM_ELEM-1:0] exp;
    bit                  cnt;
    string               tag;
  } item_t;

  item_t               sb_q[$];
  int                  n_checks;
  int                  n_errors;
  int                  ptr_m;
  logic [NUM_ELEM-1:0] last_exp;
  int                  usage [NUM_ELEM];
  bit                  done;

  dwa_selector #(.CODE_W(CODE_W)) i_dwa_selector (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_clr   (sync_clr),
    .code_valid (code_valid),
    .code       (code),
    .avg_en     (avg_en),
    .sel_main   (sel_main),
    .sel_eld    (sel_eld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string tag, logic [NUM_ELEM-1:0] act, logic [NUM_ELEM-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NUM_ELEM-1:0] model_sel(int p, int n, bit avg);
    logic [NUM_ELEM-1:0] v = '0;
    for (int j = 0; j < n; j++) begin
      v[avg ? (p + j) % NUM_ELEM : j] = 1'b1;
    end
    return v;
  endfunction

  // Driver: applies one cycle of stimulus and queues the vector due one falling edge later.
  task automatic drive(bit v, int c, bit avg, bit clr, string tag, bit cnt);
    item_t it;
    @(negedge clk);
    #(CLK_PERIOD / 4);
    code_valid = v;
    code       = CODE_W'(c);
    avg_en     = avg;
    sync_clr   = clr;
    if (clr) begin
      ptr_m    = 0;
      last_exp = '0;
    end else if (v) begin
      last_exp = model_sel(ptr_m, c, avg);
      if (avg) ptr_m = (ptr_m + c) % NUM_ELEM;
    end
    it.exp = last_exp;
    it.cnt = cnt & v & ~clr;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares after each falling edge and re-checks stability after the rising edge.
  initial begin
    item_t               it;
    logic [NUM_ELEM-1:0] held;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD / 8);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, sel_main, it.exp);
        check("R9 eld copy", sel_eld, sel_main);
        if (it.cnt) begin
          for (int e = 0; e < NUM_ELEM; e++) usage[e] += int'(sel_main[e]);
        end
        held = sel_main;
        @(posedge clk);
        #(CLK_PERIOD / 8);
        check("R7 stable after rising edge", sel_main, held);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000.0);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int mn;
    int mx;
    n_checks   = 0;
    n_errors   = 0;
    ptr_m      = 0;
    last_exp   = '0;
    done       = 1'b0;
    rst_n      = 1'b0;
    sync_clr   = 1'b0;
    avg_en     = 1'b1;
    code_valid = 1'b1;
    code       = CODE_W'(9);
    for (int e = 0; e < NUM_ELEM; e++) usage[e] = 0;

    // R1: reset holds outputs at zero even with a valid code present
    repeat (3) @(negedge clk);
    #(CLK_PERIOD / 8);
    check("R1 reset main", sel_main, '0);
    check("R1 reset eld", sel_eld, '0);
    code_valid = 1'b0;
    rst_n      = 1'b1;

    drive(0, 0, 1, 0, "R8 idle after reset", 0);
    // R5: fixed thermometer from element 0
    drive(1, 5, 0, 0, "R5 thermo 5", 0);
    drive(1, 15, 0, 0, "R5 R2 thermo full", 0);
    drive(1, 0, 0, 0, "R5 R2 thermo zero", 0);
    drive(1, 3, 0, 0, "R5 thermo 3", 0);
    // R3: rotating runs starting at pointer 0
    drive(1, 4, 1, 0, "R3 run 0..3", 0);
    drive(1, 7, 1, 0, "R3 run 4..10", 0);
    drive(1, 6, 1, 0, "R4 wrap 11..14,0,1", 0);
    drive(1, 15, 1, 0, "R2 R3 full rotate", 0);
    drive(1, 0, 1, 0, "R2 zero rotate", 0);
    // R8: idle cycles hold the vector and the pointer
    drive(0, 11, 1, 0, "R8 hold", 0);
    drive(0, 2, 0, 0, "R8 hold again", 0);
    drive(1, 3, 1, 0, "R8 pointer kept", 0);
    // R5: thermometer interlude leaves the pointer unchanged
    drive(1, 2, 0, 0, "R5 thermo 2", 0);
    drive(1, 1, 1, 0, "R5 pointer unchanged", 0);
    drive(1, 13, 1, 0, "R4 long wrap", 0);
    // R6: clear drops the concurrent code and resets the pointer
    drive(1, 9, 1, 1, "R6 clear with code", 0);
    drive(1, 3, 1, 0, "R6 run from element 0", 0);
    drive(1, 14, 1, 0, "R4 wrap after clear", 0);

    // R10: long random averaging run from a clean pointer
    drive(0, 0, 1, 1, "R6 clear before random", 0);
    for (int k = 0; k < 3000; k++) begin
      drive(($urandom % 4) != 0, int'($urandom % (NUM_ELEM + 1)), 1, 0, "R2 R3 random", 1);
    end
    drive(0, 0, 1, 0, "R8 drain", 0);
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);

    mn = usage[0];
    mx = usage[0];
    for (int e = 1; e < NUM_ELEM; e++) begin
      if (usage[e] < mn) mn = usage[e];
      if (usage[e] > mx) mx = usage[e];
    end
    n_checks++;
    if (mx - mn > 1) begin
      n_errors++;
      $display("FAIL R10 usage spread actual %0d expected <= 1", mx - mn);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule